// File: doc/BRIEF.md
# Flash Command Dispatcher with Per-Block Deferred Queues

This block is the top-level command controller of a multi-block flash array. A host writes an opcode, then an address, then a data word through a single write port. The data write launches the command. The top bits of the latched address pick one of several local engines, one engine per array block. Each engine runs read, program and erase operations for its own block. Because the engines are independent, one block can erase while another programs or reads.

When the chosen engine is already working, the command goes into a small FIFO owned by that engine. The engine pulls the next entry by itself as soon as its current operation ends, so the host never has to revisit a busy block. Each engine is an abstract timing model:

- a one-cycle preparation step raises either a sense-amplifier request or a charge-pump request;
- a run phase lasts a configurable number of cycles for each operation type;
- a one-cycle completion pulse follows.

A full queue rejects further commands. This raises a sticky overflow flag. The host sees one ready line, which tracks the queue of the block that the latched address points at.

Top module: `flash_dispatch`

## Requirements
- R1: `host_sel` selects the register a write hits: 0 = opcode, 1 = address, 2 = data; 3 is ignored. An opcode write stores `host_wdata[1:0]` as 1 = read, 2 = program or 3 = erase, and the stored opcode stays until the next opcode write. A data write launches {stored opcode, latched address, `host_wdata`}. A data write while the stored opcode is 0 (none, the reset value) starts nothing.
- R2: An address write updates the latched address only when `host_wdata[7:0]` is below `ADDR_LIMIT` (default 240) and differs from the value already held. Any other address write leaves the latched address unchanged.
- R3: The target engine is given by bits [7:6] of the latched address. A command to an idle engine with an empty queue makes `eng_busy` of that engine high after the very clock edge that samples the data write.
- R4: While a read is in its preparation and run phases, `sense_req` of its engine is high and `pump_req` is low. Program and erase raise `pump_req` instead. Both requests are low in the completion cycle and while the engine is idle.
- R5: `eng_done` of an engine is a one-cycle pulse. It appears `LAT+1` cycles after the edge that started the operation, where `LAT` is 3 for read, 8 for program and 12 for erase by default. During the pulse, `eng_op`, `eng_addr` and `eng_data` still show the finished command.
- R6: A command for an engine that is busy, or whose queue holds entries, is queued. The queue holds up to 4 entries, and the engine completes its commands in issue order.
- R7: When an engine finishes and its queue holds an entry, the next operation starts on the following edge without any host write. Consecutive completions from the queue are therefore `LAT+2` cycles apart.
- R8: Engines of different blocks run at the same time. For example, a program in block 1 and an erase in block 2 both hold `pump_req` high together.
- R9: `host_ready` is low exactly when the queue of the engine selected by the currently latched address is full.
- R10: A data write with a valid opcode aimed at a full queue is dropped and never completes. It sets `ovf_flag`, which stays high until reset.
- R11: After reset, all engines are idle, the queues are empty, `host_ready` is high, and `ovf_flag`, `eng_done`, `sense_req` and `pump_req` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 2 | Write target: 0 opcode, 1 address, 2 data |
| host_wdata | input | 16 | Host write value |
| host_ready | output | 1 | Low when the queue of the addressed block is full |
| ovf_flag | output | 1 | Sticky dropped-command flag |
| eng_busy | output | 4 | One bit per engine, high while an operation is active |
| eng_done | output | 4 | One-cycle completion pulse for each engine |
| sense_req | output | 4 | Sense-amplifier request for each engine |
| pump_req | output | 4 | Charge-pump request for each engine |
| eng_op | output | 8 | Opcode of each engine's current command, 2 bits per engine |
| eng_addr | output | 32 | Address of each engine's current command, 8 bits per engine |
| eng_data | output | 64 | Data of each engine's current command, 16 bits per engine |

## Verification
A command that starts at once shows its busy bit and request line one edge after its data write. Its completion pulse follows `LAT+1` edges after that, and a queued successor completes `LAT+2` edges after its predecessor. The bench drives inputs on falling edges and samples on the next falling edge, so it reads each result half a cycle after the edge that produced it. It measures completion timing with a cycle counter stamped at each pulse, not with fixed waits. A scoreboard of accepted commands for each engine checks every completion pulse for content and order. The overflow flag and the ready line are read in the cycle right after the offending or filling write.

// File: rtl/fd_pkg.sv
package fd_pkg;

    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 16;
    localparam int N_ENG   = 4;
    localparam int ENG_W   = $clog2(N_ENG);

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_PROG  = 2'd2,
        OP_ERASE = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        SEL_OPC  = 2'd0,
        SEL_ADDR = 2'd1,
        SEL_DATA = 2'd2,
        SEL_RSVD = 2'd3
    } hsel_e;

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } cmd_t;

    function automatic logic [ENG_W-1:0] blk_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1 -: ENG_W];
    endfunction

endpackage

// File: rtl/fd_host_port.sv
module fd_host_port
    import fd_pkg::*;
#(
    parameter int ADDR_LIMIT = 240
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [1:0]        sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [ADDR_W-1:0] addr_q,
    output logic              launch,
    output cmd_t              launch_cmd
);

    op_e               op_q;
    logic [ADDR_W-1:0] new_addr;
    logic              addr_take;

    assign new_addr  = wdata[ADDR_W-1:0];
    assign addr_take = (32'(new_addr) < ADDR_LIMIT) && (new_addr != addr_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q   <= OP_NONE;
            addr_q <= '0;
        end else if (we) begin
            case (hsel_e'(sel))
                SEL_OPC:  op_q <= op_e'(wdata[1:0]);
                SEL_ADDR: if (addr_take) addr_q <= new_addr;
                default:  ;
            endcase
        end
    end

    assign launch          = we && (hsel_e'(sel) == SEL_DATA) && (op_q != OP_NONE);
    assign launch_cmd.op   = op_q;
    assign launch_cmd.addr = addr_q;
    assign launch_cmd.data = wdata;

endmodule

// File: rtl/fd_cmd_queue.sv
module fd_cmd_queue
    import fd_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  cmd_t din,
    input  logic pop,
    output cmd_t dout,
    output logic empty,
    output logic full
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    cmd_t        mem [DEPTH];
    logic [PW:0] wr_p, rd_p;

    assign empty = (wr_p == rd_p);
    assign full  = (wr_p[PW-1:0] == rd_p[PW-1:0]) && (wr_p[PW] != rd_p[PW]);
    assign dout  = mem[rd_p[PW-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_p <= '0;
            rd_p <= '0;
        end else begin
            if (push && !full) begin
                mem[wr_p[PW-1:0]] <= din;
                wr_p <= wr_p + 1'b1;
            end
            if (pop && !empty) rd_p <= rd_p + 1'b1;
        end
    end

endmodule

// File: rtl/fd_local_engine.sv
module fd_local_engine
    import fd_pkg::*;
#(
    parameter int LAT_READ  = 3,
    parameter int LAT_PROG  = 8,
    parameter int LAT_ERASE = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  cmd_t start_cmd,
    input  logic q_avail,
    input  cmd_t q_cmd,
    output logic q_pop,
    output logic idle,
    output logic busy,
    output logic done,
    output logic sense_req,
    output logic pump_req,
    output cmd_t cur_cmd
);

    localparam int LMAX0 = (LAT_READ > LAT_PROG) ? LAT_READ : LAT_PROG;
    localparam int LMAX  = (LMAX0 > LAT_ERASE) ? LMAX0 : LAT_ERASE;
    localparam int CW    = $clog2(LMAX + 1);

    typedef enum logic [1:0] {E_IDLE, E_PREP, E_RUN, E_DONE} est_e;

    est_e          st;
    logic [CW-1:0] cnt;
    logic          active;

    function automatic logic [CW-1:0] run_len(input op_e op);
        case (op)
            OP_READ:  return CW'(LAT_READ - 1);
            OP_PROG:  return CW'(LAT_PROG - 1);
            default:  return CW'(LAT_ERASE - 1);
        endcase
    endfunction

    assign q_pop = q_avail && ((st == E_IDLE) || (st == E_DONE));

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= E_IDLE;
            cnt     <= '0;
            cur_cmd <= '0;
        end else begin
            case (st)
                E_IDLE: begin
                    if (q_avail) begin
                        cur_cmd <= q_cmd;
                        st      <= E_PREP;
                    end else if (start) begin
                        cur_cmd <= start_cmd;
                        st      <= E_PREP;
                    end
                end
                E_PREP: begin
                    cnt <= run_len(cur_cmd.op);
                    st  <= E_RUN;
                end
                E_RUN: begin
                    if (cnt == '0) st <= E_DONE;
                    else           cnt <= cnt - 1'b1;
                end
                default: begin
                    if (q_avail) begin
                        cur_cmd <= q_cmd;
                        st      <= E_PREP;
                    end else begin
                        st      <= E_IDLE;
                    end
                end
            endcase
        end
    end

    assign active    = (st == E_PREP) || (st == E_RUN);
    assign idle      = (st == E_IDLE);
    assign busy      = !idle;
    assign done      = (st == E_DONE);
    assign sense_req = active && (cur_cmd.op == OP_READ);
    assign pump_req  = active && (cur_cmd.op != OP_READ);

endmodule

// File: rtl/flash_dispatch.sv
module flash_dispatch
    import fd_pkg::*;
#(
    parameter int QDEPTH     = 4,
    parameter int LAT_READ   = 3,
    parameter int LAT_PROG   = 8,
    parameter int LAT_ERASE  = 12,
    parameter int ADDR_LIMIT = 240
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    host_we,
    input  logic [1:0]              host_sel,
    input  logic [DATA_W-1:0]       host_wdata,
    output logic                    host_ready,
    output logic                    ovf_flag,
    output logic [N_ENG-1:0]        eng_busy,
    output logic [N_ENG-1:0]        eng_done,
    output logic [N_ENG-1:0]        sense_req,
    output logic [N_ENG-1:0]        pump_req,
    output logic [2*N_ENG-1:0]      eng_op,
    output logic [ADDR_W*N_ENG-1:0] eng_addr,
    output logic [DATA_W*N_ENG-1:0] eng_data
);

    logic [ADDR_W-1:0] addr_q;
    logic              launch;
    cmd_t              launch_cmd;
    logic [ENG_W-1:0]  tgt;

    logic [N_ENG-1:0] hit, e_start, q_push, q_pop, q_empty, q_full, e_idle, drop;
    cmd_t             q_dout [N_ENG];
    cmd_t             e_cur  [N_ENG];

    fd_host_port #(.ADDR_LIMIT(ADDR_LIMIT)) u_host (
        .clk        (clk),
        .rst        (rst),
        .we         (host_we),
        .sel        (host_sel),
        .wdata      (host_wdata),
        .addr_q     (addr_q),
        .launch     (launch),
        .launch_cmd (launch_cmd)
    );

    assign tgt = blk_of(addr_q);

    for (genvar g = 0; g < N_ENG; g++) begin : g_eng
        assign hit[g]     = launch && (tgt == ENG_W'(g));
        assign e_start[g] = hit[g] && e_idle[g] && q_empty[g];
        assign q_push[g]  = hit[g] && !e_start[g] && !q_full[g];
        assign drop[g]    = hit[g] && !e_start[g] && q_full[g];

        fd_cmd_queue #(.DEPTH(QDEPTH)) u_q (
            .clk   (clk),
            .rst   (rst),
            .push  (q_push[g]),
            .din   (launch_cmd),
            .pop   (q_pop[g]),
            .dout  (q_dout[g]),
            .empty (q_empty[g]),
            .full  (q_full[g])
        );

        fd_local_engine #(
            .LAT_READ  (LAT_READ),
            .LAT_PROG  (LAT_PROG),
            .LAT_ERASE (LAT_ERASE)
        ) u_eng (
            .clk       (clk),
            .rst       (rst),
            .start     (e_start[g]),
            .start_cmd (launch_cmd),
            .q_avail   (!q_empty[g]),
            .q_cmd     (q_dout[g]),
            .q_pop     (q_pop[g]),
            .idle      (e_idle[g]),
            .busy      (eng_busy[g]),
            .done      (eng_done[g]),
            .sense_req (sense_req[g]),
            .pump_req  (pump_req[g]),
            .cur_cmd   (e_cur[g])
        );

        assign eng_op[2*g +: 2]           = e_cur[g].op;
        assign eng_addr[ADDR_W*g +: ADDR_W] = e_cur[g].addr;
        assign eng_data[DATA_W*g +: DATA_W] = e_cur[g].data;
    end

    assign host_ready = !q_full[tgt];

    always_ff @(posedge clk) begin
        if (rst) ovf_flag <= 1'b0;
        else if (|drop) ovf_flag <= 1'b1;
    end

endmodule

// File: rtl/flash_dispatch_chk.sv
module flash_dispatch_chk
    import fd_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic                    host_ready,
    input logic                    ovf_flag,
    input logic [N_ENG-1:0]        eng_busy,
    input logic [N_ENG-1:0]        eng_done,
    input logic [N_ENG-1:0]        sense_req,
    input logic [N_ENG-1:0]        pump_req,
    input logic [2*N_ENG-1:0]      eng_op,
    input logic [ADDR_W*N_ENG-1:0] eng_addr,
    input logic [DATA_W*N_ENG-1:0] eng_data
);

    p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        ovf_flag |=> ovf_flag);

    p_ovf_needs_full_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_flag) |-> $past(!host_ready));

    p_req_excl_r4: assert property (@(posedge clk) disable iff (rst)
        (sense_req & pump_req) == '0);

    for (genvar i = 0; i < N_ENG; i++) begin : g_chk
        p_idle_quiet_r4: assert property (@(posedge clk) disable iff (rst)
            !eng_busy[i] |-> (!sense_req[i] && !pump_req[i] && !eng_done[i]));

        p_done_single_r5: assert property (@(posedge clk) disable iff (rst)
            eng_done[i] |=> !eng_done[i]);

        p_done_after_req_r4: assert property (@(posedge clk) disable iff (rst)
            eng_done[i] |-> ($past(sense_req[i] || pump_req[i]) && !sense_req[i] && !pump_req[i]));

        p_cmd_hold_r6: assert property (@(posedge clk) disable iff (rst)
            (eng_busy[i] && !eng_done[i]) |=>
                ($stable(eng_op[2*i +: 2]) && $stable(eng_addr[ADDR_W*i +: ADDR_W])
                 && $stable(eng_data[DATA_W*i +: DATA_W])));
    end

endmodule

bind flash_dispatch flash_dispatch_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_ready (host_ready),
    .ovf_flag   (ovf_flag),
    .eng_busy   (eng_busy),
    .eng_done   (eng_done),
    .sense_req  (sense_req),
    .pump_req   (pump_req),
    .eng_op     (eng_op),
    .eng_addr   (eng_addr),
    .eng_data   (eng_data)
);

// File: tb/flash_dispatch_bench.sv
module flash_dispatch_bench;

    localparam int CLK_PERIOD = 10;
    localparam int LAT_R = 3;
    localparam int LAT_P = 8;
    localparam int LAT_E = 12;
    localparam int LIMIT = 240;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_we = 1'b0;
    logic [1:0]  host_sel = 2'd0;
    logic [15:0] host_wdata = 16'd0;
    logic        host_ready, ovf_flag;
    logic [3:0]  eng_busy, eng_done, sense_req, pump_req;
    logic [7:0]  eng_op;
    logic [31:0] eng_addr;
    logic [63:0] eng_data;

    flash_dispatch u_flash_dispatch (
        .clk(clk), .rst(rst), .host_we(host_we), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_ready(host_ready), .ovf_flag(ovf_flag),
        .eng_busy(eng_busy), .eng_done(eng_done), .sense_req(sense_req),
        .pump_req(pump_req), .eng_op(eng_op), .eng_addr(eng_addr), .eng_data(eng_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int last_done [4];
    int last_gap  [4];
    logic [25:0] exp_q [4][64];
    int hd [4];
    int tl [4];
    logic [1:0] m_op = 2'd0;
    logic [7:0] m_addr = 8'd0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] blk(input logic [7:0] a);
        return a[7:6];
    endfunction

    // completion scoreboard: content and order (R5, R6)
    always @(negedge clk) begin
        if (!rst) begin
            for (int i = 0; i < 4; i++) begin
                if (eng_done[i]) begin
                    last_gap[i]  = cyc - last_done[i];
                    last_done[i] = cyc;
                    if (hd[i] == tl[i]) begin
                        chk(1'b0, "R10 unexpected completion", {30'd0, 2'(i)}, 32'hFFFF);
                    end else begin
                        chk({eng_op[2*i +: 2], eng_addr[8*i +: 8], eng_data[16*i +: 16]} == exp_q[i][hd[i] % 64],
                            "R6 completion content/order",
                            {6'd0, eng_op[2*i +: 2], eng_addr[8*i +: 8], eng_data[16*i +: 16]},
                            {6'd0, exp_q[i][hd[i] % 64]});
                        hd[i]++;
                    end
                end
            end
        end
    end

    task automatic hw(input logic [1:0] sel, input logic [15:0] val);
        @(negedge clk);
        host_we = 1'b1; host_sel = sel; host_wdata = val;
        @(negedge clk);
        host_we = 1'b0;
        if (sel == 2'd0) m_op = val[1:0];
        if (sel == 2'd1 && val[7:0] < LIMIT && val[7:0] != m_addr) m_addr = val[7:0];
    endtask

    // data write; expect acceptance when accept=1 and opcode is valid
    task automatic issue(input logic [15:0] val, input bit accept);
        logic [1:0] b;
        b = blk(m_addr);
        hw(2'd2, val);
        if (accept && m_op != 2'd0) begin
            exp_q[b][tl[b] % 64] = {m_op, m_addr, val};
            tl[b]++;
        end
    endtask

    task automatic wait_idle();
        int n = 0;
        while (eng_busy != 4'd0 && n < 2000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        void'($urandom(32'd1234));
        for (int i = 0; i < 4; i++) begin
            hd[i] = 0; tl[i] = 0; last_done[i] = 0; last_gap[i] = 0;
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 reset state
        chk(eng_busy == 0, "R11 busy", 32'(eng_busy), 0);
        chk(host_ready == 1'b1, "R11 ready", 32'(host_ready), 1);
        chk(ovf_flag == 1'b0, "R11 ovf", 32'(ovf_flag), 0);
        chk((sense_req | pump_req | eng_done) == 0, "R11 requests", 32'(sense_req | pump_req | eng_done), 0);

        // R1: data write with no opcode stored starts nothing
        issue(16'h1234, 1'b1);
        chk(eng_busy == 0, "R1 no-opcode data ignored", 32'(eng_busy), 0);

        // R3/R4/R5: read on block 0
        hw(2'd0, 16'd1);
        hw(2'd1, 16'h0005);
        issue(16'hA001, 1'b1);
        chk(eng_busy[0] == 1'b1, "R3 busy after one edge", 32'(eng_busy), 1);
        chk(sense_req[0] && !pump_req[0], "R4 read raises sense", 32'({sense_req[0], pump_req[0]}), 2);
        chk(eng_addr[7:0] == 8'h05, "R2 address latched", 32'(eng_addr[7:0]), 32'h05);
        n = 0;
        while (!eng_done[0] && n < 100) begin @(negedge clk); n++; end
        chk(n == LAT_R + 1, "R5 read completion latency", n, LAT_R + 1);
        chk(!sense_req[0], "R4 sense low at completion", 32'(sense_req[0]), 0);
        wait_idle();

        // R2: invalid address ignored; R4 program raises pump
        hw(2'd1, 16'h00F5);
        hw(2'd0, 16'd2);
        issue(16'hB002, 1'b1);
        chk(eng_busy[0] && eng_addr[7:0] == 8'h05, "R2 invalid address ignored", 32'(eng_addr[7:0]), 32'h05);
        chk(pump_req[0] && !sense_req[0], "R4 program raises pump", 32'({sense_req[0], pump_req[0]}), 1);
        wait_idle();

        // R8: program block 1 and erase block 2 concurrently
        hw(2'd1, 16'h0047);
        issue(16'hC003, 1'b1);
        hw(2'd0, 16'd3);
        hw(2'd1, 16'h008A);
        issue(16'hD004, 1'b1);
        chk(pump_req[1] && pump_req[2], "R8 concurrent program and erase", 32'(pump_req), 32'h6);
        wait_idle();

        // R6/R7: three reads queued on block 1
        hw(2'd0, 16'd1);
        hw(2'd1, 16'h0050);
        issue(16'hE001, 1'b1);
        issue(16'hE002, 1'b1);
        issue(16'hE003, 1'b1);
        wait_idle();
        chk(last_gap[1] == LAT_R + 2, "R7 queued completion spacing", last_gap[1], LAT_R + 2);
        chk(hd[1] == tl[1], "R7 queue drained without host", hd[1], tl[1]);

        // R9/R10: overflow on block 3
        hw(2'd0, 16'd3);
        hw(2'd1, 16'h00C1);
        for (int k = 0; k < 5; k++) issue(16'hF000 + 16'(k), 1'b1);
        chk(host_ready == 1'b0, "R9 ready low on full queue", 32'(host_ready), 0);
        chk(ovf_flag == 1'b0, "R10 no overflow yet", 32'(ovf_flag), 0);
        issue(16'hF0FF, 1'b0);
        chk(ovf_flag == 1'b1, "R10 overflow set", 32'(ovf_flag), 1);
        hw(2'd1, 16'h0005);
        chk(host_ready == 1'b1, "R9 ready tracks addressed block", 32'(host_ready), 1);
        wait_idle();
        chk(ovf_flag == 1'b1, "R10 overflow sticky", 32'(ovf_flag), 1);

        // random mix (R1, R2, R6, R9)
        for (int it = 0; it < 300; it++) begin
            if ($urandom_range(0, 3) == 0) hw(2'd0, 16'($urandom_range(1, 3)));
            hw(2'd1, 16'($urandom_range(0, 255)));
            if (host_ready) issue(16'($urandom), 1'b1);
            repeat ($urandom_range(0, 4)) @(negedge clk);
        end
        wait_idle();
        for (int i = 0; i < 4; i++)
            chk(hd[i] == tl[i], "R6 all accepted commands completed", hd[i], tl[i]);
        chk(host_ready == 1'b1, "R9 ready after drain", 32'(host_ready), 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule